// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block turns changes on 32 general-purpose input pins into one combined interrupt request. Each pin passes through a synchroniser and is then judged either by level or by a single edge. A per-pin polarity bit picks high or rising when it is 1, and low or falling when it is 0. A per-pin source bit decides whether the pin may capture status at all. A separate per-pin enable bit decides whether captured status reaches the interrupt output. Software sees five 32-bit registers on a simple synchronous write / combinational read bus. Each register has a plain write address, a bit-set address and a bit-clear address.

Status belongs to the hardware. Software can only clear it, and only through the bit-clear address. A pin in level mode keeps its status bit set while it is still at its active level and still selected as a source, so a clear has no effect then. To retire a level interrupt, software removes the pin's source bit first or waits for the pin to go inactive, and then clears the status. Detecting both edges is left to software: it flips the polarity bit after each event.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset, every register (source select, output enable, level mode, polarity, status) reads 0 and `irqOut` is 0.
- R2: The registers sit at base addresses 0x00 (source select), 0x10 (output enable), 0x20 (level mode), 0x30 (polarity) and 0x40 (status). A plain write to a configuration base replaces the register. A read at base, base+4 or base+8 returns the register. Any other address reads 0.
- R3: At base+4, each 1 bit of write data sets that register bit. At base+8, each 1 bit clears that register bit. In both cases, 0 bits leave the register unchanged.
- R4: With level mode 0, a pin sets its status bit on a rising edge when its polarity bit is 1, and on a falling edge when it is 0. The opposite edge sets nothing.
- R5: An edge-captured status bit is cleared by writing 1 to it at 0x48, even while the pin stays at its new level.
- R6: With level mode 1, a selected pin sets its status while it is at the level named by its polarity bit. A clear at 0x48 leaves the bit set while that holds, and succeeds once the pin is inactive.
- R7: A pin whose source bit is 0 never sets its status. After the source bit is cleared, a clear at 0x48 removes a pending level status.
- R8: `irqOut` is 1 exactly when some pin has both its status bit and its output-enable bit set.
- R9: Writes to 0x40 or 0x44 leave the status register unchanged.
- R10: A pin change sets status at the third rising clock edge after it is applied (two synchroniser stages, then capture), and not earlier.
- R11: When a status set and a clear at 0x48 for the same bit fall on the same clock edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 32 | Asynchronous pin inputs |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is a status set and a software clear of the same bit landing on the same clock edge. Reaching it requires counting the synchroniser latency exactly. The bench raises a pin and then holds off the clear write for two clock edges, so that the write lands on the capture edge. The level-mode clear rule is also exercised: the bench first attempts a clear with the pin still active and selected, and then clears again after dropping the source bit. A behavioural per-pin model, updated every clock, checks the read data and the interrupt output throughout.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NUM_REGS = 5;
  localparam int NUM_CFG  = 4;
  localparam int IDX_SRC  = 0;
  localparam int IDX_EN   = 1;
  localparam int IDX_LEV  = 2;
  localparam int IDX_POL  = 3;
  localparam int IDX_STAT = 4;
  localparam logic [3:0] ALIAS_PLAIN = 4'h0;
  localparam logic [3:0] ALIAS_SET   = 4'h4;
  localparam logic [3:0] ALIAS_CLR   = 4'h8;

  // strobes from bus decode to the register datapath
  typedef struct packed {
    logic [NUM_CFG-1:0]  wrPlain;
    logic [NUM_CFG-1:0]  wrSet;
    logic [NUM_REGS-1:0] wrClr;
    logic                rdHit;
    logic [2:0]          rdIdx;
  } regStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strb
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] regIdx;
  logic [3:0]       aliasSel;
  logic             aliasOk;
  logic             idxOk;

  assign regIdx   = busAddr[ADDR_W-1:4];
  assign aliasSel = busAddr[3:0];
  assign aliasOk  = (aliasSel == ALIAS_PLAIN) || (aliasSel == ALIAS_SET) || (aliasSel == ALIAS_CLR);
  assign idxOk    = (regIdx < IDX_W'(NUM_REGS));

  always_comb begin
    strb = '0;
    if (aliasOk && idxOk) begin
      strb.rdHit = 1'b1;
      strb.rdIdx = regIdx[2:0];
    end
    for (int g = 0; g < NUM_CFG; g++) begin
      strb.wrPlain[g] = busWrEn && (regIdx == IDX_W'(g)) && (aliasSel == ALIAS_PLAIN);
      strb.wrSet[g]   = busWrEn && (regIdx == IDX_W'(g)) && (aliasSel == ALIAS_SET);
    end
    for (int g = 0; g < NUM_REGS; g++) begin
      strb.wrClr[g] = busWrEn && (regIdx == IDX_W'(g)) && (aliasSel == ALIAS_CLR);
    end
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] pinIn,
  input  logic [PINS-1:0] wrData,
  input  regStrobe_t      strb,
  output logic [PINS-1:0] rdData,
  output logic [PINS-1:0] statVec,
  output logic [PINS-1:0] enVec,
  output logic [PINS-1:0] srcVec,
  output logic [PINS-1:0] levVec,
  output logic [PINS-1:0] polVec,
  output logic [PINS-1:0] syncVec
);
  logic [PINS-1:0] cfgReg [NUM_CFG];
  logic [PINS-1:0] syncChain [SYNC_STAGES];
  logic [PINS-1:0] prevVec;
  logic [PINS-1:0] riseVec, fallVec, edgeHit, levelHit, hitVec, clrMask;

  // configuration registers with plain / set / clear write paths
  for (genvar g = 0; g < NUM_CFG; g++) begin : gCfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cfgReg[g] <= '0;
      else if (strb.wrPlain[g]) cfgReg[g] <= wrData;
      else if (strb.wrSet[g])   cfgReg[g] <= cfgReg[g] | wrData;
      else if (strb.wrClr[g])   cfgReg[g] <= cfgReg[g] & ~wrData;
    end
  end

  assign srcVec = cfgReg[IDX_SRC];
  assign enVec  = cfgReg[IDX_EN];
  assign levVec = cfgReg[IDX_LEV];
  assign polVec = cfgReg[IDX_POL];

  // input synchroniser chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[s] <= '0;
      else if (s == 0) syncChain[s] <= pinIn;
      else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
    end
  end

  assign syncVec = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVec <= '0;
    else       prevVec <= syncVec;
  end

  // event detection per pin
  assign riseVec  = syncVec & ~prevVec;
  assign fallVec  = ~syncVec & prevVec;
  assign edgeHit  = (riseVec & polVec) | (fallVec & ~polVec);
  assign levelHit = ~(syncVec ^ polVec);
  assign hitVec   = srcVec & ((levVec & levelHit) | (~levVec & edgeHit));

  // clear request; a new hit overrides it, which also keeps active level status
  assign clrMask = strb.wrClr[IDX_STAT] ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statVec <= '0;
    else       statVec <= (statVec & ~clrMask) | hitVec;
  end

  always_comb begin
    rdData = '0;
    if (strb.rdHit) begin
      if (strb.rdIdx == 3'(IDX_STAT)) rdData = statVec;
      else                            rdData = cfgReg[strb.rdIdx[1:0]];
    end
  end
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   pinIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [PINS-1:0]   busWrData,
  output logic [PINS-1:0]   busRdData,
  output logic              irqOut
);
  regStrobe_t      strb;
  logic [PINS-1:0] statVec, enVec, srcVec, levVec, polVec, syncVec;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  gpio_irq_dp #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .wrData  (busWrData),
    .strb    (strb),
    .rdData  (busRdData),
    .statVec (statVec),
    .enVec   (enVec),
    .srcVec  (srcVec),
    .levVec  (levVec),
    .polVec  (polVec),
    .syncVec (syncVec)
  );

  assign irqOut = |(statVec & enVec);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [PINS-1:0]   busWrData,
  input logic [PINS-1:0]   busRdData,
  input logic              irqOut,
  input logic [PINS-1:0]   statVec,
  input logic [PINS-1:0]   enVec,
  input logic [PINS-1:0]   srcVec,
  input logic [PINS-1:0]   levVec,
  input logic [PINS-1:0]   polVec,
  input logic [PINS-1:0]   syncVec
);
  logic [PINS-1:0] holdMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdMask <= '0;
    else       holdMask <= statVec & levVec & srcVec & ~(syncVec ^ polVec);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rstN) |-> (statVec == '0 && enVec == '0 && srcVec == '0)); // R1
  AST_PLAIN_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(8'h00)) |=> (busAddr != ADDR_W'(8'h00) || busRdData == $past(busWrData))); // R2
  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(8'h14)) |=> (busAddr != ADDR_W'(8'h14) || (busRdData & $past(busWrData)) == $past(busWrData))); // R3
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rstN) ((holdMask & ~statVec) == '0)); // R6
  AST_SOURCE_GATE: assert property (@(posedge clk) disable iff (!rstN) ((statVec & ~$past(statVec) & ~$past(srcVec)) == '0)); // R7
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN) (enVec == '0) |-> !irqOut); // R8
endmodule

bind gpio_irq_top gpio_irq_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .irqOut    (irqOut),
  .statVec   (statVec),
  .enVec     (enVec),
  .srcVec    (srcVec),
  .levVec    (levVec),
  .polVec    (polVec),
  .syncVec   (syncVec)
);

// File: tb/gpio_irq_top_tb.sv
`timescale 1ns/1ps
module gpio_irq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinIn = '0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit doneFlag = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_top u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  // behavioural reference, one pin at a time
  logic [31:0] mS1, mS2, mPrev, mSrc, mEn, mLev, mPol, mStat;

  always @(posedge clk or negedge rstN) begin
    logic [31:0] nStat;
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mSrc = '0; mEn = '0; mLev = '0; mPol = '0; mStat = '0;
    end else begin
      nStat = mStat;
      if (busWrEn && busAddr == 8'h48) nStat = nStat & ~busWrData;
      for (int i = 0; i < 32; i++) begin
        bit ev;
        if (mLev[i]) ev = (mS2[i] == mPol[i]);
        else if (mPol[i]) ev = mS2[i] && !mPrev[i];
        else ev = !mS2[i] && mPrev[i];
        if (ev && mSrc[i]) nStat[i] = 1'b1;
      end
      if (busWrEn) begin
        case (busAddr)
          8'h00: mSrc = busWrData;  8'h04: mSrc = mSrc | busWrData;  8'h08: mSrc = mSrc & ~busWrData;
          8'h10: mEn  = busWrData;  8'h14: mEn  = mEn  | busWrData;  8'h18: mEn  = mEn  & ~busWrData;
          8'h20: mLev = busWrData;  8'h24: mLev = mLev | busWrData;  8'h28: mLev = mLev & ~busWrData;
          8'h30: mPol = busWrData;  8'h34: mPol = mPol | busWrData;  8'h38: mPol = mPol & ~busWrData;
          default: ;
        endcase
      end
      mStat = nStat;
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
    end
  end

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08: return mSrc;
      8'h10, 8'h14, 8'h18: return mEn;
      8'h20, 8'h24, 8'h28: return mLev;
      8'h30, 8'h34, 8'h38: return mPol;
      8'h40, 8'h44, 8'h48: return mStat;
      default: return '0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R2 read data, R8 interrupt)
  always @(negedge clk) begin
    if (rstN && !doneFlag) begin
      check(busRdData, modelRead(busAddr), "R2 model read");
      check({31'b0, irqOut}, {31'b0, |(mStat & mEn)}, "R8 model irq");
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    step(1);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #5;
    d = busRdData;
  endtask

  task automatic finishRun();
    doneFlag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    for (int r = 0; r < 5; r++) begin
      rd(8'(r * 16), v); check(v, 32'h0, "R1 reset reg");
    end
    check({31'b0, irqOut}, 32'h0, "R1 reset irq");

    // R2 plain writes and map
    wr(8'h10, 32'hA5A5_0000); rd(8'h10, v); check(v, 32'hA5A5_0000, "R2 enable plain");
    wr(8'h30, 32'h1234_5678); rd(8'h38, v); check(v, 32'h1234_5678, "R2 polarity via clr addr read");
    rd(8'h50, v); check(v, 32'h0, "R2 unmapped");
    rd(8'h0C, v); check(v, 32'h0, "R2 bad alias");
    wr(8'h10, 32'h0); wr(8'h30, 32'h0);

    // R3 set and clear aliases
    wr(8'h00, 32'h0000_00F0); wr(8'h04, 32'h1); wr(8'h08, 32'h10);
    rd(8'h00, v); check(v, 32'h0000_00E1, "R3 set/clr alias");
    wr(8'h00, 32'h0);
    wr(8'h48, 32'hFFFF_FFFF);

    // R4 / R10 rising edge on pin 3
    wr(8'h04, 32'h8); wr(8'h14, 32'h8); wr(8'h34, 32'h8);
    step(1); pinIn[3] = 1'b1;
    step(2); rd(8'h40, v); check(v, 32'h0, "R10 not before third edge");
    step(1); rd(8'h40, v); check(v, 32'h8, "R10 R4 rising captured");
    check({31'b0, irqOut}, 32'h1, "R8 irq raised");
    // R5 clear edge status while pin stays high
    wr(8'h48, 32'h8); rd(8'h40, v); check(v, 32'h0, "R5 edge clear");
    check({31'b0, irqOut}, 32'h0, "R8 irq dropped");
    // R4 opposite edge ignored
    pinIn[3] = 1'b0; step(5); rd(8'h40, v); check(v, 32'h0, "R4 falling ignored when pol=1");

    // R4 falling edge pin 5, not enabled to output
    pinIn[5] = 1'b1; step(5);
    wr(8'h04, 32'h20);
    pinIn[5] = 1'b0; step(5);
    rd(8'h40, v); check(v, 32'h20, "R4 falling captured");
    check({31'b0, irqOut}, 32'h0, "R8 masked status");
    wr(8'h48, 32'h20);

    // R6 / R7 level high pin 7
    wr(8'h24, 32'h80); wr(8'h34, 32'h80); wr(8'h04, 32'h80);
    pinIn[7] = 1'b1; step(5);
    rd(8'h40, v); check(v, 32'h80, "R6 level captured");
    wr(8'h48, 32'h80); rd(8'h40, v); check(v, 32'h80, "R6 clear blocked while active");
    wr(8'h08, 32'h80); wr(8'h48, 32'h80);
    rd(8'h40, v); check(v, 32'h0, "R7 clear after deselect");
    step(5); rd(8'h40, v); check(v, 32'h0, "R7 deselected pin stays quiet");

    // R6 level low pin 9, clear once inactive
    wr(8'h24, 32'h200); wr(8'h04, 32'h200);
    step(2); rd(8'h40, v); check(v, 32'h200, "R6 level low captured");
    pinIn[9] = 1'b1; step(5);
    wr(8'h48, 32'h200); rd(8'h40, v); check(v, 32'h0, "R6 clear when inactive");

    // R9 plain and set writes to status ignored
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, v); check(v, 32'h0, "R9 status write ignored");

    // R11 set wins over same-edge clear, pin 11
    wr(8'h04, 32'h800); wr(8'h34, 32'h800);
    step(1); pinIn[11] = 1'b1;
    step(2);
    busAddr = 8'h48; busWrData = 32'h800; busWrEn = 1'b1;
    step(1); busWrEn = 1'b0;
    rd(8'h40, v); check(v, 32'h800, "R11 set wins");
    wr(8'h48, 32'h800); rd(8'h40, v); check(v, 32'h0, "R11 later clear");

    step(2);
    finishRun();
  end
endmodule